// File: doc/BRIEF.md
# Sector Program/Erase Permission Gate

This block sits between the command decoder of a dual-boot flash array and the program/erase engine. For each program or erase request it decides in the same cycle whether the target sector may be written. It checks the stored per-sector protection bits and three pin-level overrides: an accelerate pin that freezes the whole array, a write-protect pin that freezes the boot sectors at both ends of the array, and a supply-lockout flag from the voltage monitor. A refused request raises a registered one-cycle deny pulse, together with a code that says which rule refused it.

The gate tracks whether a granted operation is still running. If the supply drops below the lockout level during an operation, the gate cancels the operation and returns the array to read mode. The write-protect level is captured at the first cycle of each command sequence and is held for the rest of that sequence, so a pin change in the middle of a sequence has no effect. The gate also presents the 4-bit non-volatile lock register as a 16-bit read word.

Top module: `sector_guard`

## Requirements
- R1: `lock_word[3:0]` equals `lock_reg` bit for bit (bit 0 secure-sector protection, bit 1 persistent-mode lock, bit 2 password-mode lock, bit 3 persistent one-time-programmable bit), and `lock_word[15:4]` reads as all ones.
- R2: With `acc_n`, `wp_n` high, no lockout and no operation running, a request to sector i is granted when `sect_prot[i]` is 0 and refused when it is 1.
- R3: While `acc_n` is low, no request to any sector is granted.
- R4: While the effective write-protect level is low, requests to sectors 0, 1, N-2 and N-1 are refused whatever their stored bits. All other sectors, and these four when the level is high, follow `sect_prot`.
- R5: The effective write-protect level is `wp_n` sampled in the first cycle that `seq_active` is high, and it keeps that value while `seq_active` stays high. Outside a sequence it is `wp_n` itself.
- R6: No request is granted while `lockout` is high, in the cycle right after it was high, or in the first cycle after reset.
- R7: If `lockout` is high while `op_busy` is high, then in the next cycle `op_busy` is 0, `read_mode` is 1 and `abort_pulse` is 1 for exactly one cycle.
- R8: `deny_pulse` is high in the cycle after a request (`req_valid`=1) that was not granted, and low otherwise. `deny_code` then holds the refusal code, and 0 when `deny_pulse` is low.
- R9: A grant sets `op_busy` from the next cycle. `op_busy` clears the cycle after `op_done`, and a request made while `op_busy` is high is refused. `read_mode` is the inverse of `op_busy`.
- R10: Refusal codes in priority order: 1 lockout (including the one-cycle hold), 2 busy, 3 accelerate low, 4 write-protect on a boot sector, 5 stored protection. A granted request has code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seq_active | input | 1 | High for the duration of a command sequence |
| req_valid | input | 1 | Program/erase request this cycle |
| req_sector | input | SEC_W | Target sector index |
| wp_n | input | 1 | Write-protect pin, low protects boot sectors |
| acc_n | input | 1 | Accelerate pin, low locks all sectors |
| lockout | input | 1 | Supply below lockout threshold |
| sect_prot | input | NUM_SECTORS | Stored per-sector protection bits, 1 = protected |
| lock_reg | input | LOCK_W | Non-volatile lock register bits |
| op_done | input | 1 | Running program/erase has finished |
| grant | output | 1 | Request accepted (combinational) |
| deny_pulse | output | 1 | One-cycle pulse after a refused request |
| deny_code | output | 3 | Refusal reason that goes with `deny_pulse` |
| op_busy | output | 1 | A granted operation is in progress |
| abort_pulse | output | 1 | Operation cancelled by lockout |
| read_mode | output | 1 | Array is in read mode |
| lock_word | output | WORD_W | Lock register as a read word |

## Verification
The bench drives write-protect changes inside a command sequence in both directions. A design that used the live pin would grant a boot-sector write it should refuse, or refuse one it should grant. It releases lockout and requests at once, so a gate without the one-cycle hold grants too early. It raises lockout over a running operation; a design that missed this would leave `op_busy` set and give no abort pulse. It also stacks several overrides on the same request, so that a wrong priority order shows up as a wrong `deny_code`, and it targets both ends of the array, so that protecting only the low boot sectors is caught.

// File: rtl/sg_pkg.sv
package sg_pkg;

  typedef enum logic [2:0] {
    DC_NONE    = 3'd0,
    DC_LOCKOUT = 3'd1,
    DC_BUSY    = 3'd2,
    DC_ACCEL   = 3'd3,
    DC_WPIN    = 3'd4,
    DC_STORED  = 3'd5
  } deny_code_e;

  localparam int unsigned BOOT_PER_END = 2;

  // True for the boot sectors at either end of an array of n sectors.
  function automatic logic is_boot_edge(input int unsigned idx, input int unsigned n);
    return (idx < BOOT_PER_END) || (idx + BOOT_PER_END >= n);
  endfunction

  function automatic logic in_array(input int unsigned idx, input int unsigned n);
    return idx < n;
  endfunction

endpackage

// File: rtl/sg_wp_capture.sv
module sg_wp_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic seq_active,
  input  logic wp_n,
  output logic seq_first,
  output logic wp_eff
);
  logic seq_q;
  logic wp_q;

  assign seq_first = seq_active & ~seq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= 1'b0;
      wp_q  <= 1'b1;
    end else begin
      seq_q <= seq_active;
      if (seq_first) wp_q <= wp_n;
    end
  end

  always_comb begin
    if (seq_first)       wp_eff = wp_n;
    else if (seq_active) wp_eff = wp_q;
    else                 wp_eff = wp_n;
  end
endmodule

// File: rtl/sg_supply_guard.sv
module sg_supply_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic lockout,
  output logic write_block
);
  logic lo_q;

  // Reset value 1 keeps writes blocked in the first cycle after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_q <= 1'b1;
    else        lo_q <= lockout;
  end

  assign write_block = lockout | lo_q;
endmodule

// File: rtl/sg_policy.sv
module sg_policy #(
  parameter int unsigned NUM_SECTORS = 16,
  localparam int unsigned SEC_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic [SEC_W-1:0]       req_sector,
  input  logic [NUM_SECTORS-1:0] sect_prot,
  input  logic                   acc_n,
  input  logic                   wp_eff,
  input  logic                   write_block,
  input  logic                   op_busy,
  output sg_pkg::deny_code_e     code
);
  import sg_pkg::*;

  logic boot_hit;
  logic stored_hit;
  logic valid_idx;

  assign valid_idx  = in_array(32'(req_sector), NUM_SECTORS);
  assign boot_hit   = is_boot_edge(32'(req_sector), NUM_SECTORS);
  assign stored_hit = valid_idx ? sect_prot[req_sector] : 1'b1;

  always_comb begin
    code = DC_NONE;
    if (write_block)            code = DC_LOCKOUT;
    else if (op_busy)           code = DC_BUSY;
    else if (!acc_n)            code = DC_ACCEL;
    else if (!wp_eff && boot_hit) code = DC_WPIN;
    else if (stored_hit)        code = DC_STORED;
  end
endmodule

// File: rtl/sg_op_track.sv
module sg_op_track (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  input  logic op_done,
  input  logic lockout,
  output logic op_busy,
  output logic abort_pulse
);
  logic busy_q;
  logic abort_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      abort_q <= busy_q & lockout;
      if (lockout)      busy_q <= 1'b0;
      else if (grant)   busy_q <= 1'b1;
      else if (op_done) busy_q <= 1'b0;
    end
  end

  assign op_busy     = busy_q;
  assign abort_pulse = abort_q;
endmodule

// File: rtl/sector_guard.sv
module sector_guard #(
  parameter int unsigned NUM_SECTORS = 16,
  parameter int unsigned LOCK_W      = 4,
  parameter int unsigned WORD_W      = 16,
  localparam int unsigned SEC_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   seq_active,
  input  logic                   req_valid,
  input  logic [SEC_W-1:0]       req_sector,
  input  logic                   wp_n,
  input  logic                   acc_n,
  input  logic                   lockout,
  input  logic [NUM_SECTORS-1:0] sect_prot,
  input  logic [LOCK_W-1:0]      lock_reg,
  input  logic                   op_done,
  output logic                   grant,
  output logic                   deny_pulse,
  output logic [2:0]             deny_code,
  output logic                   op_busy,
  output logic                   abort_pulse,
  output logic                   read_mode,
  output logic [WORD_W-1:0]      lock_word
);
  import sg_pkg::*;

  logic       seq_first;
  logic       wp_eff;
  logic       write_block;
  deny_code_e rule_code;
  logic       refused;
  logic       deny_q;
  logic [2:0] code_q;

  sg_wp_capture u_wp (
    .clk       (clk),
    .rst_n     (rst_n),
    .seq_active(seq_active),
    .wp_n      (wp_n),
    .seq_first (seq_first),
    .wp_eff    (wp_eff)
  );

  sg_supply_guard u_supply (
    .clk        (clk),
    .rst_n      (rst_n),
    .lockout    (lockout),
    .write_block(write_block)
  );

  sg_policy #(.NUM_SECTORS(NUM_SECTORS)) u_policy (
    .req_sector (req_sector),
    .sect_prot  (sect_prot),
    .acc_n      (acc_n),
    .wp_eff     (wp_eff),
    .write_block(write_block),
    .op_busy    (op_busy),
    .code       (rule_code)
  );

  sg_op_track u_op (
    .clk        (clk),
    .rst_n      (rst_n),
    .grant      (grant),
    .op_done    (op_done),
    .lockout    (lockout),
    .op_busy    (op_busy),
    .abort_pulse(abort_pulse)
  );

  assign grant   = req_valid & (rule_code == DC_NONE);
  assign refused = req_valid & ~grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deny_q <= 1'b0;
      code_q <= 3'd0;
    end else begin
      deny_q <= refused;
      code_q <= refused ? 3'(rule_code) : 3'd0;
    end
  end

  assign deny_pulse = deny_q;
  assign deny_code  = code_q;
  assign read_mode  = ~op_busy;

  // Lock bits in the low positions, the rest of the word reads as ones.
  for (genvar g = 0; g < int'(WORD_W); g++) begin : g_word
    if (g < int'(LOCK_W)) begin : g_bit
      assign lock_word[g] = lock_reg[g];
    end else begin : g_one
      assign lock_word[g] = 1'b1;
    end
  end
endmodule

// File: rtl/sector_guard_chk.sv
module sector_guard_chk #(
  parameter int unsigned NUM_SECTORS = 16,
  localparam int unsigned SEC_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   seq_active,
  input logic                   req_valid,
  input logic [SEC_W-1:0]       req_sector,
  input logic                   acc_n,
  input logic                   lockout,
  input logic [NUM_SECTORS-1:0] sect_prot,
  input logic                   grant,
  input logic                   deny_pulse,
  input logic [2:0]             deny_code,
  input logic                   op_busy,
  input logic                   abort_pulse,
  input logic                   read_mode,
  input logic                   wp_eff
);
  import sg_pkg::*;

  p_stored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && in_array(32'(req_sector), NUM_SECTORS)) |-> !sect_prot[req_sector]);

  p_accel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_n |-> !grant);

  p_boot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && is_boot_edge(32'(req_sector), NUM_SECTORS)) |-> wp_eff);

  p_wp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && seq_active && $past(seq_active)) |-> $stable(wp_eff));

  p_lockout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lockout || $past(lockout)) |-> !grant);

  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && lockout) |=> (abort_pulse && !op_busy && read_mode));

  p_deny_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !grant) |=> deny_pulse);

  p_no_deny_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !grant) |=> !deny_pulse);

  p_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    deny_pulse == (deny_code != 3'd0));

  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_busy |-> !grant);

  p_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> op_busy);
endmodule

bind sector_guard sector_guard_chk #(.NUM_SECTORS(NUM_SECTORS)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .seq_active (seq_active),
  .req_valid  (req_valid),
  .req_sector (req_sector),
  .acc_n      (acc_n),
  .lockout    (lockout),
  .sect_prot  (sect_prot),
  .grant      (grant),
  .deny_pulse (deny_pulse),
  .deny_code  (deny_code),
  .op_busy    (op_busy),
  .abort_pulse(abort_pulse),
  .read_mode  (read_mode),
  .wp_eff     (wp_eff)
);

// File: tb/test_sector_guard.sv
module test_sector_guard;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seq_active = 1'b0, req_valid = 1'b0, wp_n = 1'b1, acc_n = 1'b1;
  logic lockout = 1'b0, op_done = 1'b0;
  logic [SW-1:0] req_sector = '0;
  logic [N-1:0] sect_prot = '0;
  logic [3:0] lock_reg = '0;
  logic grant, deny_pulse, op_busy, abort_pulse, read_mode;
  logic [2:0] deny_code;
  logic [15:0] lock_word;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Reference state
  bit m_seq_prev, m_wp_hold, m_lo_prev, m_busy, m_deny, m_abort;
  int m_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_guard i_sector_guard (
    .clk(clk), .rst_n(rst_n), .seq_active(seq_active), .req_valid(req_valid),
    .req_sector(req_sector), .wp_n(wp_n), .acc_n(acc_n), .lockout(lockout),
    .sect_prot(sect_prot), .lock_reg(lock_reg), .op_done(op_done),
    .grant(grant), .deny_pulse(deny_pulse), .deny_code(deny_code),
    .op_busy(op_busy), .abort_pulse(abort_pulse), .read_mode(read_mode),
    .lock_word(lock_word)
  );

  task automatic chk(input string phase, input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", req, phase, act, exp);
    end
  endtask

  function automatic string reason_tag(input int r);
    case (r)
      1: return "R6 lockout";
      2: return "R9 busy";
      3: return "R3 accel";
      4: return "R4 write-protect";
      5: return "R2 stored";
      default: return "R2 grant";
    endcase
  endfunction

  function automatic bit boot_sector(input int s);
    return s == 0 || s == 1 || s == N - 2 || s == N - 1;
  endfunction

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input string phase, input bit rq, input int sec, input bit sq,
                      input bit wp, input bit ac, input bit lo, input bit dn);
    bit wpe, g;
    int why;
    chk(phase, "R8 deny_pulse", deny_pulse, m_deny);
    chk(phase, "R10 deny_code", deny_code, m_code);
    chk(phase, "R9 op_busy", op_busy, m_busy);
    chk(phase, "R7 read_mode", read_mode, !m_busy);
    chk(phase, "R7 abort_pulse", abort_pulse, m_abort);
    req_valid = rq; req_sector = SW'(sec); seq_active = sq;
    wp_n = wp; acc_n = ac; lockout = lo; op_done = dn;
    #1;
    if (sq && !m_seq_prev) wpe = wp;
    else if (sq)           wpe = m_wp_hold;
    else                   wpe = wp;
    if (lo || m_lo_prev)                why = 1;
    else if (m_busy)                    why = 2;
    else if (!ac)                       why = 3;
    else if (!wpe && boot_sector(sec))  why = 4;
    else if (sect_prot[sec])            why = 5;
    else                                why = 0;
    g = rq && (why == 0);
    chk(phase, reason_tag(why), grant, g);
    chk(phase, "R1 lock_word", lock_word, {12'hFFF, lock_reg});
    @(posedge clk);
    m_deny  = rq && !g;
    m_code  = m_deny ? why : 0;
    m_abort = m_busy && lo;
    if (lo)      m_busy = 1'b0;
    else if (g)  m_busy = 1'b1;
    else if (dn) m_busy = 1'b0;
    m_lo_prev = lo;
    if (sq && !m_seq_prev) m_wp_hold = wp;
    m_seq_prev = sq;
    @(negedge clk);
  endtask

  task automatic idle(input string phase);
    step(phase, 0, 0, 0, 1, 1, 0, 1);
  endtask

  // Request then let any started operation finish.
  task automatic try_sec(input string phase, input int sec, input bit wp, input bit ac);
    step(phase, 1, sec, 0, wp, ac, 0, 0);
    step(phase, 0, 0, 0, wp, ac, 0, 1);
  endtask

  initial begin
    m_seq_prev = 0; m_wp_hold = 1; m_lo_prev = 1; m_busy = 0;
    m_deny = 0; m_abort = 0; m_code = 0;
    sect_prot = 16'h0F00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // Reset state
    chk("reset", "R9 op_busy", op_busy, 0);
    chk("reset", "R7 read_mode", read_mode, 1);
    chk("reset", "R8 deny_pulse", deny_pulse, 0);
    // First cycle after reset is held off (R6)
    step("R6 post-reset", 1, 4, 0, 1, 1, 0, 0);
    idle("R6 post-reset");

    // R1 lock word
    foreach (lock_reg[i]) begin end
    lock_reg = 4'hA; idle("R1");
    lock_reg = 4'h5; idle("R1");
    lock_reg = 4'h3; idle("R1");

    // R2 stored protection, all sectors, pins high
    for (int s = 0; s < N; s++) try_sec("R2", s, 1, 1);
    // R3 accelerate low
    for (int s = 0; s < N; s++) try_sec("R3", s, 1, 0);
    // R4 write-protect low, then boot sector with stored bit set
    for (int s = 0; s < N; s++) try_sec("R4", s, 0, 1);
    sect_prot = 16'h8F00;
    try_sec("R4 stored high", N - 1, 1, 1);
    try_sec("R10 wp over stored", N - 1, 0, 1);
    sect_prot = 16'h0F00;

    // R5 latch high then pin drops mid-sequence: boot writes still allowed
    step("R5", 0, 0, 1, 1, 1, 0, 0);
    step("R5", 1, 0, 1, 0, 1, 0, 0);
    step("R5", 0, 0, 1, 0, 1, 0, 1);
    step("R5", 0, 0, 0, 1, 1, 0, 1);
    // latch low then pin rises mid-sequence: boot writes still refused
    step("R5", 0, 0, 1, 0, 1, 0, 0);
    step("R5", 1, N - 1, 1, 1, 1, 0, 0);
    step("R5", 1, 3, 1, 1, 1, 0, 0);
    step("R5", 0, 0, 0, 1, 1, 0, 1);
    idle("R5");

    // R6 lockout and its one-cycle hold
    step("R6", 1, 4, 0, 1, 1, 1, 0);
    step("R6", 1, 4, 0, 1, 1, 0, 0);
    step("R6", 1, 4, 0, 1, 1, 0, 0);
    step("R6", 0, 0, 0, 1, 1, 0, 1);

    // R7 lockout during a running operation
    step("R7", 1, 5, 0, 1, 1, 0, 0);
    step("R7", 0, 0, 0, 1, 1, 1, 0);
    step("R7", 0, 0, 0, 1, 1, 0, 0);
    idle("R7");
    idle("R7");

    // R9 request while busy, then done
    step("R9", 1, 6, 0, 1, 1, 0, 0);
    step("R9", 1, 7, 0, 1, 1, 0, 0);
    step("R9", 0, 0, 0, 1, 1, 0, 0);
    step("R9", 0, 0, 0, 1, 1, 0, 1);
    idle("R9");

    // R10 stacked overrides
    step("R10", 1, 0, 0, 0, 0, 1, 0);
    idle("R10"); idle("R10");
    step("R10", 1, 4, 0, 1, 1, 0, 0);
    step("R10", 1, 0, 0, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 1, 1, 0, 1);
    step("R10", 1, 0, 0, 0, 0, 0, 0);
    step("R10", 1, 1, 0, 0, 1, 0, 0);
    idle("R10");

    // Mixed traffic
    for (int k = 0; k < 600; k++) begin
      if (k % 37 == 0) sect_prot = N'($urandom);
      if (k % 53 == 0) lock_reg = 4'($urandom);
      step("RND", ($urandom % 2) == 1, int'($urandom % N), ($urandom % 4) != 0,
           ($urandom % 2) == 1, ($urandom % 8) != 0, ($urandom % 12) == 0,
           ($urandom % 3) == 0);
    end
    idle("end");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule